// File: doc/BRIEF.md
# Dual-Clock FIFO Channel with Reset-Selected Write Mode

This block is one channel of a first-in first-out buffer whose write side and read side run on separate clocks that need not be related. Words of `W` bits enter on the write clock and leave through a registered output on the read clock. The depth is `2**AW` words, 256 by default. Each side keeps a binary pointer and publishes it as a Gray code. The other side captures that code through two flip-flops and converts it back to binary, so only one bit changes per step when it crosses domains.

A single dual-purpose input, `wen2_ld`, picks the write mode. Its level is captured while reset is held low and stays fixed until the next reset. A high level selects dual-enable mode: a write needs the primary enable low and this input high, which lets several channels be chained for more depth. A low level selects threshold mode: the same input becomes a load strobe. With the primary enable low and this input low, the write is turned away from the FIFO and `ofs_load` is raised for an external threshold loader.

The loader drives `empty_ofs` and `full_ofs`. The channel uses them as the thresholds of its two early-warning flags. All status flags are active low. The output bus can be switched to high impedance.

Top module: `fifo_chan`

## Requirements
- R1: While `rst_n` is low at the clock edges of both domains, `empty_n` and `aempty_n` read 0, `full_n` and `afull_n` read 1, the output register reads all zeros, and both pointers return to location zero.
- R2: The level of `wen2_ld` seen at write-clock edges during reset sets the mode (1 = dual-enable, 0 = threshold). Changes of `wen2_ld` after reset do not change the mode.
- R3: In dual-enable mode, a word is stored at a write-clock edge only when `wen1_n` is 0 and `wen2_ld` is 1. Any other combination stores nothing, and `ofs_load` stays 0.
- R4: In threshold mode, `wen1_n` = 0 with `wen2_ld` = 1 stores a word. `wen1_n` = 0 with `wen2_ld` = 0 stores nothing and drives `ofs_load` to 1.
- R5: A word moves to the output register at a read-clock edge only when `ren1_n` and `ren2_n` are both 0. If either is 1, the output register keeps its value.
- R6: Writes are ignored while `full_n` is 0 and reads are ignored while `empty_n` is 0. Words leave in the order they were accepted.
- R7: After a write into an empty channel, `empty_n` rises on the second read-clock rising edge after that write edge. After a read from a full channel, `full_n` rises on the second write-clock rising edge after that read edge.
- R8: `aempty_n` is 0 exactly when the read-side word count is at or below `empty_ofs`. `afull_n` is 0 exactly when the write-side free space is at or below `full_ofs`.
- R9: With `oe_n` = 1 the `q` bus is high impedance. With `oe_n` = 0 it shows the output register.
- R10: `full_n` falls on the same write edge that stores the last free word. `empty_n` falls on the same read edge that takes the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| wdata | input | W | Write data |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable or threshold load strobe, level captured during reset |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| empty_ofs | input | AW | Almost-empty threshold |
| full_ofs | input | AW | Almost-full threshold |
| q | output | W | Read data, high impedance when disabled |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read-clock domain |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| afull_n | output | 1 | Almost-full flag, active low, write-clock domain |
| ofs_load | output | 1 | Strobe to the threshold loader in threshold mode |

## Verification
The bench builds the channel with `AW` = 3 and `W` = 9, so the FIFO holds eight words. That makes every fill level from empty to full reachable one word at a time. At each level the bench sweeps every value of both thresholds against the almost flags. Full-overflow and empty-underflow attempts, the two-edge crossing latency of both flags, both write modes, and a streaming run with unrelated 8 ns and 11 ns clocks are then checked against a queue model in a few hundred cycles.

// File: rtl/fifo_chan_pkg.sv
// Package fifo_chan_pkg
// Shared mode encoding and Gray-code helpers for the dual-clock FIFO channel.
// Assumes pointer widths of at most 32 bits.
package fifo_chan_pkg;

    typedef enum logic {
        MODE_THRESH   = 1'b0,
        MODE_DUAL_WEN = 1'b1
    } wmode_e;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary; upper zero bits stay zero.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_ptr_sync.sv
// Module fifo_ptr_sync
// Carries a Gray-coded pointer into the destination clock domain through two
// flip-flops and returns it in binary. Assumes the source changes at most one
// bit per source clock edge and that reset spans two destination edges.
module fifo_ptr_sync #(
    parameter int PW = 9
) (
    input  logic          dst_clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_i,
    output logic [PW-1:0] bin_o
);
    import fifo_chan_pkg::*;

    logic [PW-1:0] meta_q;
    logic [PW-1:0] stab_q;

    // Two-stage capture of the foreign pointer.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= gray_i;
            stab_q <= meta_q;
        end
    end

    // Decode the stable Gray value.
    always_comb begin
        logic [31:0] wide;
        wide  = from_gray(32'(stab_q));
        bin_o = wide[PW-1:0];
    end

endmodule

// File: rtl/fifo_wr_ctl.sv
// Module fifo_wr_ctl
// Write-side control: captures the write mode during reset, qualifies writes,
// advances the write pointer and derives full / almost-full from the
// synchronized read pointer. Assumes reset is held low for at least two wclk edges.
module fifo_wr_ctl #(
    parameter int AW = 8
) (
    input  logic        wclk,
    input  logic        rst_n,
    input  logic        wen1_n,
    input  logic        wen2_ld,
    input  logic [AW-1:0] full_ofs,
    input  logic [AW:0] rbin_s,
    output logic        wr_en,
    output logic [AW-1:0] waddr,
    output logic [AW:0] wgray,
    output logic        full_n,
    output logic        afull_n,
    output logic        ofs_load
);
    import fifo_chan_pkg::*;

    localparam logic [AW:0] DEPTH_V = (AW+1)'(1) << AW;

    wmode_e      mode_q;
    logic [AW:0] wbin;
    logic [AW:0] wbin_nxt;
    logic [AW:0] occ;
    logic [AW:0] room;

    // Mode follows wen2_ld while reset is low, then stays frozen.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            mode_q <= wmode_e'(wen2_ld);
        end
    end

    // Both modes store only with wen1_n low and wen2_ld high; the modes
    // differ in what the remaining combination means.
    assign wr_en    = rst_n && !wen1_n && wen2_ld && full_n;
    assign ofs_load = rst_n && (mode_q == MODE_THRESH) && !wen1_n && !wen2_ld;

    assign wbin_nxt = wbin + (AW+1)'(wr_en);

    // Write pointer in binary and its published Gray image.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= (AW+1)'(to_gray(32'(wbin_nxt)));
        end
    end

    // Occupancy and free space as seen from the write side.
    assign occ     = wbin - rbin_s;
    assign room    = DEPTH_V - occ;
    assign full_n  = (occ != DEPTH_V);
    assign afull_n = !(room <= {1'b0, full_ofs});
    assign waddr   = wbin[AW-1:0];

    p_reset_full_r1: assert property (@(posedge wclk)
        !rst_n |=> (full_n && afull_n && wbin == '0));

    p_mode_hold_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

    p_load_no_write_r4: assert property (@(posedge wclk) disable iff (!rst_n)
        (mode_q == MODE_THRESH && !wen1_n && !wen2_ld) |=> $stable(wbin));

    p_no_overflow_r6: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wbin));

    p_occ_bound_r6: assert property (@(posedge wclk) disable iff (!rst_n)
        rst_n |-> (occ <= DEPTH_V));

endmodule

// File: rtl/fifo_rd_ctl.sv
// Module fifo_rd_ctl
// Read-side control: qualifies reads with both enables, advances the read
// pointer and derives empty / almost-empty from the synchronized write pointer.
// Assumes reset is held low for at least two rclk edges.
module fifo_rd_ctl #(
    parameter int AW = 8
) (
    input  logic        rclk,
    input  logic        rst_n,
    input  logic        ren1_n,
    input  logic        ren2_n,
    input  logic [AW-1:0] empty_ofs,
    input  logic [AW:0] wbin_s,
    output logic        rd_en,
    output logic [AW-1:0] raddr,
    output logic [AW:0] rgray,
    output logic        empty_n,
    output logic        aempty_n
);
    import fifo_chan_pkg::*;

    logic [AW:0] rbin;
    logic [AW:0] rbin_nxt;
    logic [AW:0] occ;

    // A read needs both enables and a non-empty channel.
    assign rd_en    = rst_n && !ren1_n && !ren2_n && empty_n;
    assign rbin_nxt = rbin + (AW+1)'(rd_en);

    // Read pointer in binary and its published Gray image.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= (AW+1)'(to_gray(32'(rbin_nxt)));
        end
    end

    // Occupancy as seen from the read side.
    assign occ      = wbin_s - rbin;
    assign empty_n  = (occ != '0);
    assign aempty_n = !(occ <= {1'b0, empty_ofs});
    assign raddr    = rbin[AW-1:0];

    p_reset_empty_r1: assert property (@(posedge rclk)
        !rst_n |=> (!empty_n && !aempty_n && rbin == '0));

    p_no_underflow_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> $stable(rbin));

    p_rd_bound_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        rst_n |-> (occ <= ((AW+1)'(1) << AW)));

endmodule

// File: rtl/fifo_store.sv
// Module fifo_store
// Storage array with a write port on wclk and a registered read port on rclk.
// The output register clears on reset; the array itself is not reset.
// Assumes the controllers never read a location that is being written.
module fifo_store #(
    parameter int W  = 9,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  q_reg
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wclk) begin
        if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    // Load the output register on a qualified read.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            q_reg <= '0;
        end else if (rd_en) begin
            q_reg <= mem[raddr];
        end
    end

endmodule

// File: rtl/fifo_chan.sv
// Module fifo_chan
// Dual-clock FIFO channel of 2**AW words of W bits with a write mode captured
// at reset, two read enables, active-low status flags and a tri-state output.
// Assumes rst_n is held low across at least two edges of each clock.
module fifo_chan #(
    parameter int W  = 9,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [W-1:0]  wdata,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic          oe_n,
    input  logic [AW-1:0] empty_ofs,
    input  logic [AW-1:0] full_ofs,
    output logic [W-1:0]  q,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          full_n,
    output logic          afull_n,
    output logic          ofs_load
);
    localparam int PW = AW + 1;

    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rbin_s;
    logic [W-1:0]  q_reg;

    fifo_wr_ctl #(.AW(AW)) u_wr (
        .wclk     (wclk),
        .rst_n    (rst_n),
        .wen1_n   (wen1_n),
        .wen2_ld  (wen2_ld),
        .full_ofs (full_ofs),
        .rbin_s   (rbin_s),
        .wr_en    (wr_en),
        .waddr    (waddr),
        .wgray    (wgray),
        .full_n   (full_n),
        .afull_n  (afull_n),
        .ofs_load (ofs_load)
    );

    fifo_rd_ctl #(.AW(AW)) u_rd (
        .rclk      (rclk),
        .rst_n     (rst_n),
        .ren1_n    (ren1_n),
        .ren2_n    (ren2_n),
        .empty_ofs (empty_ofs),
        .wbin_s    (wbin_s),
        .rd_en     (rd_en),
        .raddr     (raddr),
        .rgray     (rgray),
        .empty_n   (empty_n),
        .aempty_n  (aempty_n)
    );

    fifo_ptr_sync #(.PW(PW)) u_w2r (
        .dst_clk (rclk),
        .rst_n   (rst_n),
        .gray_i  (wgray),
        .bin_o   (wbin_s)
    );

    fifo_ptr_sync #(.PW(PW)) u_r2w (
        .dst_clk (wclk),
        .rst_n   (rst_n),
        .gray_i  (rgray),
        .bin_o   (rbin_s)
    );

    fifo_store #(.W(W), .AW(AW)) u_mem (
        .wclk  (wclk),
        .wr_en (wr_en),
        .waddr (waddr),
        .wdata (wdata),
        .rclk  (rclk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .raddr (raddr),
        .q_reg (q_reg)
    );

    // Drive the bus only when output enable is low.
    assign q = oe_n ? {W{1'bz}} : q_reg;

    p_hold_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren1_n || ren2_n) |=> $stable(q_reg));

    p_reset_out_r1: assert property (@(posedge rclk)
        !rst_n |=> (q_reg == '0));

endmodule

// File: tb/sim_fifo_chan.sv
`timescale 1ns/1ps
module sim_fifo_chan;
    localparam int W  = 9;
    localparam int AW = 3;
    localparam int D  = 1 << AW;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    always #4   wclk = ~wclk;
    always #5.5 rclk = ~rclk;

    logic          rst_n = 1'b0;
    logic [W-1:0]  wdata = '0;
    logic          wen1_n = 1'b1, wen2_ld = 1'b1;
    logic          ren1_n = 1'b1, ren2_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [AW-1:0] empty_ofs = '0, full_ofs = '0;
    logic [W-1:0]  q;
    logic          empty_n, aempty_n, full_n, afull_n, ofs_load;

    fifo_chan #(.W(W), .AW(AW)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wdata(wdata),
        .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .oe_n(oe_n), .empty_ofs(empty_ofs), .full_ofs(full_ofs), .q(q),
        .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n),
        .afull_n(afull_n), .ofs_load(ofs_load)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] mq[$];
    logic [W-1:0] last_q = '0;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    task automatic do_reset(input logic m);
        @(negedge wclk);
        rst_n = 1'b0; wen2_ld = m; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        repeat (4) @(negedge rclk);
        chk(empty_n == 1'b0,  "R1 empty_n", 32'(empty_n), 0);
        chk(aempty_n == 1'b0, "R1 aempty_n", 32'(aempty_n), 0);
        chk(full_n == 1'b1,   "R1 full_n", 32'(full_n), 1);
        chk(afull_n == 1'b1,  "R1 afull_n", 32'(afull_n), 1);
        chk(q === '0,         "R1 q", 32'(q), 0);
        @(negedge wclk);
        rst_n = 1'b1; wen2_ld = 1'b1;
        mq.delete(); last_q = '0;
        settle();
    endtask

    task automatic push(input logic [W-1:0] d, input logic e1, input logic e2);
        @(negedge wclk);
        wdata = d; wen1_n = e1; wen2_ld = e2;
        if (!e1 && e2 && mq.size() < D) mq.push_back(d);
        @(negedge wclk);
        wen1_n = 1'b1; wen2_ld = 1'b1;
    endtask

    task automatic pop(input logic r1, input logic r2, input string req);
        @(negedge rclk);
        ren1_n = r1; ren2_n = r2;
        @(negedge rclk);
        ren1_n = 1'b1; ren2_n = 1'b1;
        if (!r1 && !r2 && mq.size() > 0) last_q = mq.pop_front();
        chk(q === last_q, req, 32'(q), 32'(last_q));
    endtask

    // R8: sweep both thresholds at a settled fill level k.
    task automatic level_chk(input int k);
        chk(empty_n == (k != 0), "R8 empty_n level", 32'(empty_n), 32'(k != 0));
        chk(full_n == (k != D),  "R8 full_n level", 32'(full_n), 32'(k != D));
        for (int e = 0; e < D; e++) begin
            empty_ofs = AW'(e); full_ofs = AW'(e);
            #1;
            chk(aempty_n == !(k <= e), "R8 aempty_n", 32'(aempty_n), 32'(!(k <= e)));
            chk(afull_n == !((D - k) <= e), "R8 afull_n", 32'(afull_n), 32'(!((D - k) <= e)));
        end
        empty_ofs = '0; full_ofs = '0;
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n;
        do_reset(1'b1);

        // R9: output enable
        oe_n = 1'b1; #1;
        chk(q === {W{1'bz}}, "R9 hi-z", 32'(q), 32'h1ff);
        oe_n = 1'b0; #1;
        chk(q === '0, "R9 driven", 32'(q), 0);

        // R7: empty_n latency after a write into an empty channel
        @(negedge wclk); wdata = 9'h0a5; wen1_n = 1'b0;
        @(posedge wclk); #1 wen1_n = 1'b1; mq.push_back(9'h0a5);
        n = 0;
        do begin @(posedge rclk); #1; n++; end while (!empty_n && n < 8);
        chk(n == 2, "R7 empty_n edges", 32'(n), 2);
        settle();

        // R3 / R2: dual-enable mode ignores other enable combinations
        @(negedge wclk); wdata = 9'h111; wen1_n = 1'b0; wen2_ld = 1'b0; #1;
        chk(ofs_load == 1'b0, "R2 R3 no load strobe", 32'(ofs_load), 0);
        @(negedge wclk); wen1_n = 1'b1; wen2_ld = 1'b1;
        push(9'h122, 1'b1, 1'b1);
        push(9'h133, 1'b1, 1'b0);
        settle();
        pop(1'b1, 1'b0, "R5 ren1 high holds");
        pop(1'b0, 1'b1, "R5 ren2 high holds");
        pop(1'b0, 1'b0, "R3 only qualified word");
        chk(empty_n == 1'b0, "R10 empty on last read", 32'(empty_n), 0);
        settle();

        // R8 / R10 / R6: fill one word at a time
        for (int k = 0; k <= D; k++) begin
            level_chk(k);
            if (k < D) begin
                push(W'(k * 37 + 5), 1'b0, 1'b1);
                if (k == D - 1) chk(full_n == 1'b0, "R10 full on last write", 32'(full_n), 0);
                settle();
            end
        end
        push(9'h1aa, 1'b0, 1'b1);
        settle();
        chk(full_n == 1'b0, "R6 still full", 32'(full_n), 0);

        // R7: full_n latency after a read from a full channel
        @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b0;
        @(posedge rclk); #1 ren1_n = 1'b1; ren2_n = 1'b1;
        last_q = mq.pop_front();
        n = 0;
        do begin @(posedge wclk); #1; n++; end while (!full_n && n < 8);
        chk(n == 2, "R7 full_n edges", 32'(n), 2);
        chk(q === last_q, "R6 first word", 32'(q), 32'(last_q));
        settle();

        // R8 / R6: drain with level checks
        for (int k = D - 1; k > 0; k--) begin
            level_chk(k);
            pop(1'b0, 1'b0, "R6 order on drain");
            settle();
        end
        level_chk(0);

        // R6: read while empty is ignored
        pop(1'b0, 1'b0, "R6 read on empty holds");
        push(9'h055, 1'b0, 1'b1);
        settle();
        pop(1'b0, 1'b0, "R6 pointer unmoved by empty read");
        settle();

        // R4 / R2: threshold mode
        do_reset(1'b0);
        @(negedge wclk); wdata = 9'h0ff; wen1_n = 1'b0; wen2_ld = 1'b0; #1;
        chk(ofs_load == 1'b1, "R4 load strobe", 32'(ofs_load), 1);
        @(negedge wclk); wen1_n = 1'b1; wen2_ld = 1'b1;
        settle();
        chk(empty_n == 1'b0, "R4 load is not a write", 32'(empty_n), 0);
        for (int i = 0; i < 3; i++) push(W'(i + 9'h140), 1'b0, 1'b1);
        @(negedge wclk); wen1_n = 1'b0; wen2_ld = 1'b0; #1;
        chk(ofs_load == 1'b1, "R2 mode held after reset", 32'(ofs_load), 1);
        @(negedge wclk); wen1_n = 1'b1; wen2_ld = 1'b1;
        settle();
        for (int i = 0; i < 3; i++) pop(1'b0, 1'b0, "R4 words stored");
        settle();

        // R6: streaming with unrelated clocks
        fork
            begin
                int i = 0;
                while (i < 40) begin
                    @(negedge wclk);
                    if (full_n) begin
                        wdata = W'(i * 13 + 7); wen1_n = 1'b0;
                        mq.push_back(wdata); i++;
                    end else begin
                        wen1_n = 1'b1;
                    end
                end
                @(negedge wclk); wen1_n = 1'b1;
            end
            begin
                int got = 0;
                bit act = 1'b0;
                while (got < 40) begin
                    @(negedge rclk);
                    if (act) begin
                        last_q = mq.pop_front();
                        chk(q === last_q, "R6 stream order", 32'(q), 32'(last_q));
                        got++;
                    end
                    act = empty_n && (got + 1 < 40 || !act) && got < 40;
                    if (got >= 40) act = 1'b0;
                    ren1_n = !act; ren2_n = !act;
                end
                ren1_n = 1'b1; ren2_n = 1'b1;
            end
        join
        settle();
        chk(empty_n == 1'b0, "R6 stream drained", 32'(empty_n), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule